// File: doc/BRIEF.md
# Selectable Ratio Clock Divider Bank

This block sits behind the oscillator of a zero-delay clock generator and turns one high-rate clock into two families of slower clocks. A feedback divider produces the clock that returns to the phase comparator. The same divided clock also leaves the block as a reference output. A second divider drives a bank of four matched output clocks. Each divider has its own 2-bit ratio code, so the feedback ratio and the bank ratio are set separately.

Three controls act on every output. An active-high master reset clears both dividers and forces every output low. A mode input chooses between the divided oscillator clock and a bypass mode. In bypass mode the chosen reference goes straight to every output. A source input picks which of two reference inputs is used. Ratio codes are taken only at a divider's terminal count, so a change to a code never shortens a pulse that is already in progress.

Top module: `clkdiv_bank`

## Requirements
- R1: The feedback divider divides the oscillator by 12, 16, 20 or 24 for `fb_sel` codes 0, 1, 2 or 3. Its output is high for half of each period, measured in half oscillator cycles.
- R2: The bank divider divides the oscillator by 3, 4, 6 or 12 for `out_sel` codes 0, 1, 2 or 3.
- R3: `ref_clk_out` always carries the same waveform as `fb_clk`.
- R4: While `mstr_rst` is high, all bank outputs, `fb_clk` and `ref_clk_out` are low. This holds in bypass mode too.
- R5: After `mstr_rst` falls, the outputs stay low through the first oscillator rising edge. They go high on the second rising edge and then toggle.
- R6: When `pll_en` is low and reset is low, every output follows the selected reference level.
- R7: `src_xtal` high selects `ref_xtal` as the reference. `src_xtal` low selects `ref_ext`.
- R8: The four bank outputs are always equal to one another.
- R9: With the bank divider at 3, the output is high for 3 half-cycles and low for 3 half-cycles. Both oscillator edges are used to get this.
- R10: The bank outputs and the feedback output make their first rising transition on the same oscillator edge.
- R11: A new ratio code takes effect only after the current divider period ends. A pulse already running finishes with the old length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | High-rate oscillator clock |
| mstr_rst | input | 1 | Active-high master reset; clears the dividers and forces the outputs low |
| pll_en | input | 1 | 1 = divided oscillator clock, 0 = bypass to the reference |
| src_xtal | input | 1 | 1 = crystal-path reference, 0 = external reference |
| ref_ext | input | 1 | External reference input |
| ref_xtal | input | 1 | Crystal-path reference input |
| fb_sel | input | 2 | Feedback ratio code |
| out_sel | input | 2 | Bank ratio code |
| bank_clk | output | 4 | Matched bank output clocks |
| fb_clk | output | 1 | Feedback clock |
| ref_clk_out | output | 1 | Reference output clock, the same as the feedback clock |

## Verification
Every ratio code of each divider is run, and the high and low widths of a full pulse are measured in half cycles. Only a correct ratio table and the correct duty logic give both widths right. The odd ratio of 3 shows whether the falling-edge half-cycle extension works. A width of 2 or 4 half-cycles would point to a divider that uses only the rising edge.

A ratio code is changed right after a rising edge. This shows whether the code is latched at the terminal count or used at once: a runt pulse would give a shorter high width. The bypass tests drive the two references to opposite levels, so a wrong source choice is visible at the outputs. Reset is checked both while dividing and in bypass mode.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int CNT_W   = 5;
  localparam int SEL_W   = 2;
  localparam int FB_BASE = 12;
  localparam int FB_STEP = 4;

  function automatic logic [CNT_W-1:0] fb_ratio(input logic [SEL_W-1:0] code);
    return CNT_W'(FB_BASE + FB_STEP * int'(code));
  endfunction

  function automatic logic [CNT_W-1:0] bank_ratio(input logic [SEL_W-1:0] code);
    case (code)
      2'd0:    return CNT_W'(3);
      2'd1:    return CNT_W'(4);
      2'd2:    return CNT_W'(6);
      default: return CNT_W'(12);
    endcase
  endfunction
endpackage

// File: rtl/rdiv_core.sv
module rdiv_core #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] ratio_i,
  output logic          clk_o,
  output logic          load_o,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] ratio_o
);
  logic          run_q;
  logic [CW-1:0] cnt_q, ratio_q;
  logic          hi_p, odd_p, hi_n, odd_n;
  logic          wrap;

  assign wrap   = run_q && (cnt_q == ratio_q - CW'(1));
  assign load_o = !run_q || wrap;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      run_q   <= 1'b0;
      cnt_q   <= '0;
      ratio_q <= '0;
      hi_p    <= 1'b0;
      odd_p   <= 1'b0;
    end else begin
      run_q <= 1'b1;
      if (!run_q) begin
        ratio_q <= ratio_i;
      end else if (wrap) begin
        cnt_q   <= '0;
        ratio_q <= ratio_i;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
      hi_p  <= run_q && (cnt_q < (ratio_q >> 1));
      odd_p <= ratio_q[0];
    end
  end

  // falling-edge copy stretches odd ratios by half a cycle
  always_ff @(negedge clk or posedge rst) begin
    if (rst) begin
      hi_n  <= 1'b0;
      odd_n <= 1'b0;
    end else begin
      hi_n  <= hi_p;
      odd_n <= odd_p;
    end
  end

  assign clk_o   = hi_p | (hi_n & odd_n);
  assign cnt_o   = cnt_q;
  assign ratio_o = ratio_q;
endmodule

// File: rtl/ref_mux.sv
module ref_mux (
  input  logic src_xtal,
  input  logic ref_ext,
  input  logic ref_xtal,
  output logic ref_sel
);
  assign ref_sel = src_xtal ? ref_xtal : ref_ext;
endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
  import clkdiv_pkg::*;
#(
  parameter int NUM_OUT = 4,
  parameter int CW      = CNT_W
) (
  input  logic               clk_osc,
  input  logic               mstr_rst,
  input  logic               pll_en,
  input  logic               src_xtal,
  input  logic               ref_ext,
  input  logic               ref_xtal,
  input  logic [1:0]         fb_sel,
  input  logic [1:0]         out_sel,
  output logic [NUM_OUT-1:0] bank_clk,
  output logic               fb_clk,
  output logic               ref_clk_out
);
  logic          ref_sel_w;
  logic          fb_div_w, bank_div_w;
  logic          fb_load_w, bank_load_w;
  logic [CW-1:0] fb_cnt_w, bank_cnt_w, fb_ratio_w, bank_ratio_w;
  logic [CW-1:0] fb_req_w, bank_req_w;

  assign fb_req_w   = CW'(fb_ratio(fb_sel));
  assign bank_req_w = CW'(bank_ratio(out_sel));

  ref_mux u_refmux (
    .src_xtal (src_xtal),
    .ref_ext  (ref_ext),
    .ref_xtal (ref_xtal),
    .ref_sel  (ref_sel_w)
  );

  rdiv_core #(.CW(CW)) u_fbdiv (
    .clk     (clk_osc),
    .rst     (mstr_rst),
    .ratio_i (fb_req_w),
    .clk_o   (fb_div_w),
    .load_o  (fb_load_w),
    .cnt_o   (fb_cnt_w),
    .ratio_o (fb_ratio_w)
  );

  rdiv_core #(.CW(CW)) u_bankdiv (
    .clk     (clk_osc),
    .rst     (mstr_rst),
    .ratio_i (bank_req_w),
    .clk_o   (bank_div_w),
    .load_o  (bank_load_w),
    .cnt_o   (bank_cnt_w),
    .ratio_o (bank_ratio_w)
  );

  logic src_clk_fb, src_clk_bank;
  assign src_clk_fb   = pll_en ? fb_div_w   : ref_sel_w;
  assign src_clk_bank = pll_en ? bank_div_w : ref_sel_w;

  assign fb_clk      = !mstr_rst && src_clk_fb;
  assign ref_clk_out = !mstr_rst && src_clk_fb;

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_bank
    assign bank_clk[g] = !mstr_rst && src_clk_bank;
  end
endmodule

// File: rtl/clkdiv_bank_chk.sv
module clkdiv_bank_chk #(
  parameter int NUM_OUT = 4,
  parameter int CW      = 5
) (
  input logic               clk_osc,
  input logic               mstr_rst,
  input logic               pll_en,
  input logic               ref_sel_w,
  input logic [NUM_OUT-1:0] bank_clk,
  input logic               fb_clk,
  input logic               ref_clk_out,
  input logic               fb_load_w,
  input logic               bank_load_w,
  input logic [CW-1:0]      fb_cnt_w,
  input logic [CW-1:0]      bank_cnt_w,
  input logic [CW-1:0]      fb_ratio_w,
  input logic [CW-1:0]      bank_ratio_w
);
  // R4: outputs quiet while reset is held
  always @(posedge clk_osc) begin
    if (mstr_rst === 1'b1)
      p_rst_quiet_r4: assert (bank_clk == '0 && !fb_clk && !ref_clk_out);
  end

  p_bypass_r6: assert property (@(posedge clk_osc) disable iff (mstr_rst)
    !pll_en |-> (fb_clk == ref_sel_w && bank_clk == {NUM_OUT{ref_sel_w}}));

  p_fb_cnt_r1: assert property (@(posedge clk_osc) disable iff (mstr_rst)
    (fb_ratio_w != '0) |-> (fb_cnt_w < fb_ratio_w));

  p_bank_cnt_r2: assert property (@(posedge clk_osc) disable iff (mstr_rst)
    (bank_ratio_w != '0) |-> (bank_cnt_w < bank_ratio_w));

  p_bank_hold_r11: assert property (@(posedge clk_osc) disable iff (mstr_rst)
    !$stable(bank_ratio_w) |-> $past(bank_load_w));

  p_fb_hold_r11: assert property (@(posedge clk_osc) disable iff (mstr_rst)
    !$stable(fb_ratio_w) |-> $past(fb_load_w));
endmodule

bind clkdiv_bank clkdiv_bank_chk #(.NUM_OUT(NUM_OUT), .CW(CW)) u_chk (
  .clk_osc      (clk_osc),
  .mstr_rst     (mstr_rst),
  .pll_en       (pll_en),
  .ref_sel_w    (ref_sel_w),
  .bank_clk     (bank_clk),
  .fb_clk       (fb_clk),
  .ref_clk_out  (ref_clk_out),
  .fb_load_w    (fb_load_w),
  .bank_load_w  (bank_load_w),
  .fb_cnt_w     (fb_cnt_w),
  .bank_cnt_w   (bank_cnt_w),
  .fb_ratio_w   (fb_ratio_w),
  .bank_ratio_w (bank_ratio_w)
);

// File: tb/clkdiv_bank_tb_top.sv
module clkdiv_bank_tb_top;
  logic       clk = 1'b0;
  logic       mr = 1'b1, pll_en = 1'b1, xsel = 1'b0, r_ext = 1'b0, r_xtal = 1'b0;
  logic [1:0] fb_sel = 2'd0, out_sel = 2'd0;
  logic [3:0] bank;
  logic       fb, rout;

  int n_run = 0, n_fail = 0;
  int bank_mm = 0, ref_mm = 0;

  typedef struct { string req; int which; int hi; int lo; } exp_t;
  exp_t exp_q[$];

  always #2 clk = ~clk;

  clkdiv_bank dut_i (
    .clk_osc(clk), .mstr_rst(mr), .pll_en(pll_en), .src_xtal(xsel),
    .ref_ext(r_ext), .ref_xtal(r_xtal), .fb_sel(fb_sel), .out_sel(out_sel),
    .bank_clk(bank), .fb_clk(fb), .ref_clk_out(rout)
  );

  task automatic half();
    @(posedge clk or negedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic pick(input int which);
    case (which)
      0:       return bank[0];
      1:       return fb;
      default: return rout;
    endcase
  endfunction

  function automatic int bank_n(input int c);
    case (c)
      0: return 3;
      1: return 4;
      2: return 6;
      default: return 12;
    endcase
  endfunction

  // continuous checks on matched bank (R8) and ref/feedback equality (R3)
  always @(posedge clk or negedge clk) begin
    #1;
    if (bank != {4{bank[0]}}) bank_mm++;
    if (rout !== fb) ref_mm++;
  end

  // monitor: pops expected pulse widths and measures one full pulse
  initial begin
    forever begin
      exp_t it;
      int hi, lo;
      wait (exp_q.size() != 0);
      it = exp_q[0];
      while (pick(it.which) != 1'b0) half();
      while (pick(it.which) != 1'b1) half();
      hi = 0;
      while (pick(it.which) == 1'b1) begin hi++; half(); end
      lo = 0;
      while (pick(it.which) == 1'b0) begin lo++; half(); end
      chk(hi == it.hi, it.req, "high half-cycles", hi, it.hi);
      chk(lo == it.lo, it.req, "low half-cycles", lo, it.lo);
      void'(exp_q.pop_front());
    end
  end

  task automatic expect_pulse(input string req, input int which, input int n);
    exp_t e;
    e.req = req; e.which = which; e.hi = n; e.lo = n;
    exp_q.push_back(e);
    wait (exp_q.size() == 0);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) half();
    // R4 reset state
    chk(bank == 4'h0 && !fb && !rout, "R4", "outputs in reset", {bank, fb, rout}, 0);
    pll_en = 1'b0; r_ext = 1'b1; half();
    chk(bank == 4'h0 && !fb && !rout, "R4", "bypass in reset", {bank, fb, rout}, 0);
    pll_en = 1'b1; r_ext = 1'b0;

    // R5 / R10 release and aligned start
    @(posedge clk); #1; mr = 1'b0;
    @(posedge clk); #1;
    chk(bank == 4'h0 && !fb, "R5", "first edge after release", {bank, fb}, 0);
    @(posedge clk); #1;
    chk(bank == 4'hF && fb && rout, "R10", "aligned first rise", {bank, fb, rout}, 6'h3F);

    // R2 / R9 bank ratios
    for (int c = 0; c < 4; c++) begin
      out_sel = 2'(c);
      repeat (60) half();
      expect_pulse((c == 0) ? "R9" : "R2", 0, bank_n(c));
    end

    // R1 / R3 feedback ratios
    for (int c = 0; c < 4; c++) begin
      fb_sel = 2'(c);
      repeat (100) half();
      expect_pulse("R1", 1, 12 + 4 * c);
      expect_pulse("R3", 2, 12 + 4 * c);
    end

    // R11 code change mid-pulse
    begin
      int hi, lo, hi2;
      out_sel = 2'd3;
      repeat (60) half();
      while (bank[0] != 1'b0) half();
      while (bank[0] != 1'b1) half();
      out_sel = 2'd0;
      hi = 0; while (bank[0]) begin hi++; half(); end
      lo = 0; while (!bank[0]) begin lo++; half(); end
      hi2 = 0; while (bank[0]) begin hi2++; half(); end
      chk(hi == 12, "R11", "old pulse high kept", hi, 12);
      chk(lo == 12, "R11", "old pulse low kept", lo, 12);
      chk(hi2 == 3, "R11", "new ratio after terminal", hi2, 3);
    end

    // R6 / R7 bypass and source select
    pll_en = 1'b0; xsel = 1'b0; r_ext = 1'b1; r_xtal = 1'b0; #1;
    chk(bank == 4'hF && fb && rout, "R6", "bypass ext high", {bank, fb, rout}, 6'h3F);
    r_ext = 1'b0; #1;
    chk(bank == 4'h0 && !fb && !rout, "R6", "bypass ext low", {bank, fb, rout}, 0);
    xsel = 1'b1; r_xtal = 1'b1; #1;
    chk(bank == 4'hF && fb, "R7", "crystal path high", {bank, fb}, 5'h1F);
    r_ext = 1'b1; r_xtal = 1'b0; #1;
    chk(bank == 4'h0 && !fb, "R7", "crystal path low", {bank, fb}, 0);

    // R4 reset while running
    pll_en = 1'b1; xsel = 1'b0; r_ext = 1'b0;
    repeat (21) half();
    mr = 1'b1; #1;
    chk(bank == 4'h0 && !fb && !rout, "R4", "reset mid-run", {bank, fb, rout}, 0);
    repeat (6) half();
    chk(bank == 4'h0 && !fb && !rout, "R4", "held in reset", {bank, fb, rout}, 0);

    chk(bank_mm == 0, "R8", "bank mismatch samples", bank_mm, 0);
    chk(ref_mm == 0, "R3", "ref/fb mismatch samples", ref_mm, 0);
    finish_run();
  end
endmodule